// File: doc/BRIEF.md
# Paired Half/Done Interrupt Controller

This block gathers completion events from sixteen DMA channels into one interrupt line. The first eight channels are ordinary transfer channels and the last eight are dedicated channels. Every channel reports two events: a half-done pulse when half of its transfer has been moved, and a done pulse when the whole transfer has finished. Each event latches a sticky pending flag. An interrupt fires when any flag is latched and its matching enable bit is set.

Software uses a simple register port with two 32-bit registers. One register holds the enables and the other holds the pending flags. A handler reads the pending register and services the events it finds. It then writes ones to clear exactly those events. Events that arrive while the handler is running stay latched, so the handler can read the register again and pick them up. There is no state sequencer. All state is two banks of flip-flops, and the read path is combinational.

Top module: `paired_irq_ctrl`

## Requirements
- R1: After reset, both registers read as zero and `irq_out` is low.
- R2: The enable register sits at address 0x0. A write with `reg_sel` and `reg_wr` high stores all 32 bits, and a read returns the stored value in the same cycle.
- R3: The pending register sits at address 0x4. Channel n drives bit 2n with its half-done event and bit 2n+1 with its done event. Normal channel k is channel k (bits 2k and 2k+1). Dedicated channel k is channel 8+k (bits 16+2k and 17+2k).
- R4: An event pulse sets its pending bit at the next clock edge whether or not the bit is enabled. The bit then holds until software clears it.
- R5: Writing to the pending register clears every bit written as 1 at the next edge. Bits written as 0 keep their value. A write never sets a bit.
- R6: When an event pulse and a clearing write for the same bit fall in the same cycle, the bit ends up set.
- R7: `irq_out` is high exactly when some bit is set in both the pending and the enable register, and it follows both registers with no extra delay.
- R8: Writing all ones to the pending register clears every flag. Writing zero to the enable register drops `irq_out` while the pending flags are kept.
- R9: A write to any address other than 0x0 or 0x4 changes nothing. So does any access with `reg_sel` low. Reads of other addresses return zero.
- R10: An event that arrives in the same cycle as a clear of other bits stays pending and shows on the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| norm_half | input | 8 | Half-done pulses of the normal channels |
| norm_done | input | 8 | Done pulses of the normal channels |
| ded_half | input | 8 | Half-done pulses of the dedicated channels |
| ded_done | input | 8 | Done pulses of the dedicated channels |
| reg_sel | input | 1 | Register access select |
| reg_wr | input | 1 | Write strobe, valid with `reg_sel` |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Two functions can meet in the same cycle: a channel's event pulse setting a pending bit, and a software write that clears pending bits. The bench drives a done pulse in the same cycle as a write of one to that same bit, then reads the register and expects the bit still set. It also drives a pulse on one channel while clearing a different bit. It then expects the cleared bit to be gone and the new bit to be present.

// File: rtl/paired_irq_pkg.sv
package paired_irq_pkg;
    localparam int REG_DW      = 32;
    localparam int EVTS_PER_CH = 2;
    localparam int EVT_HALF    = 0;
    localparam int EVT_DONE    = 1;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_ENABLE,
        TGT_PENDING
    } reg_target_e;
endpackage

// File: rtl/paired_irq_chan.sv
module paired_irq_chan (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] evt,
    input  logic [1:0] clr,
    output logic [1:0] pend
);
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | evt;
    end

    for (genvar j = 0; j < 2; j++) begin : g_chk
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            evt[j] |=> pend[j]); // R6
        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[j] && !evt[j]) |=> !pend[j]); // R5
        AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr[j] && !evt[j]) |=> $stable(pend[j])); // R4
    end
endmodule

// File: rtl/paired_irq_regif.sv
module paired_irq_regif
    import paired_irq_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NBITS    = 32,
    parameter int OFS_EN   = 0,
    parameter int OFS_PEND = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_DW-1:0] wdata,
    input  logic [NBITS-1:0]  pend_q,
    output logic [NBITS-1:0]  en_q,
    output logic [NBITS-1:0]  clr_mask,
    output logic [REG_DW-1:0] rdata
);
    reg_target_e tgt;

    always_comb begin
        if (!sel)                              tgt = TGT_NONE;
        else if (addr == ADDR_W'(OFS_EN))      tgt = TGT_ENABLE;
        else if (addr == ADDR_W'(OFS_PEND))    tgt = TGT_PENDING;
        else                                   tgt = TGT_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                          en_q <= '0;
        else if (wr && tgt == TGT_ENABLE)    en_q <= wdata[NBITS-1:0];
    end

    always_comb begin
        clr_mask = '0;
        rdata    = '0;
        unique case (tgt)
            TGT_ENABLE:  rdata = REG_DW'(en_q);
            TGT_PENDING: begin
                rdata = REG_DW'(pend_q);
                if (wr) clr_mask = wdata[NBITS-1:0];
            end
            default: ;
        endcase
    end

    AST_STRAY_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt != TGT_PENDING) |-> (clr_mask == '0)); // R9
    AST_EN_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && tgt == TGT_ENABLE) |=> $stable(en_q)); // R9
endmodule

// File: rtl/paired_irq_ctrl.sv
module paired_irq_ctrl
    import paired_irq_pkg::*;
#(
    parameter int NUM_NORMAL = 8,
    parameter int NUM_DEDIC  = 8,
    parameter int ADDR_W     = 8,
    parameter int OFS_EN     = 0,
    parameter int OFS_PEND   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_NORMAL-1:0] norm_half,
    input  logic [NUM_NORMAL-1:0] norm_done,
    input  logic [NUM_DEDIC-1:0]  ded_half,
    input  logic [NUM_DEDIC-1:0]  ded_done,
    input  logic                  reg_sel,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [REG_DW-1:0]     reg_wdata,
    output logic [REG_DW-1:0]     reg_rdata,
    output logic                  irq_out
);
    localparam int NCH   = NUM_NORMAL + NUM_DEDIC;
    localparam int NBITS = NCH * EVTS_PER_CH;

    logic [NBITS-1:0] pend_all;
    logic [NBITS-1:0] en_q;
    logic [NBITS-1:0] clr_mask;
    logic [NCH-1:0]   ev_half;
    logic [NCH-1:0]   ev_done;

    paired_irq_regif #(
        .ADDR_W  (ADDR_W),
        .NBITS   (NBITS),
        .OFS_EN  (OFS_EN),
        .OFS_PEND(OFS_PEND)
    ) u_regif (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (reg_sel),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .pend_q  (pend_all),
        .en_q    (en_q),
        .clr_mask(clr_mask),
        .rdata   (reg_rdata)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        if (c < NUM_NORMAL) begin : g_norm
            assign ev_half[c] = norm_half[c];
            assign ev_done[c] = norm_done[c];
        end else begin : g_ded
            assign ev_half[c] = ded_half[c-NUM_NORMAL];
            assign ev_done[c] = ded_done[c-NUM_NORMAL];
        end

        paired_irq_chan u_chan (
            .clk  (clk),
            .rst_n(rst_n),
            .evt  ({ev_done[c], ev_half[c]}),
            .clr  (clr_mask[EVTS_PER_CH*c +: EVTS_PER_CH]),
            .pend (pend_all[EVTS_PER_CH*c +: EVTS_PER_CH])
        );
    end

    assign irq_out = |(pend_all & en_q);

    AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && reg_addr == ADDR_W'(OFS_EN) && reg_wdata == '0)
        |=> !irq_out); // R8
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (pend_all != '0)); // R7
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (en_q != '0)); // R7
endmodule

// File: tb/paired_irq_ctrl_bench.sv
`timescale 1ns/1ps
module paired_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  norm_half = '0, norm_done = '0, ded_half = '0, ded_done = '0;
    logic        reg_sel = 1'b0, reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    paired_irq_ctrl u_paired_irq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .norm_half(norm_half), .norm_done(norm_done),
        .ded_half(ded_half), .ded_done(ded_done),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: optional write plus event bits given in pending-bit order.
    task automatic cycle(bit wr, logic [7:0] addr, logic [31:0] data, logic [31:0] ev);
        @(negedge clk);
        reg_sel = wr; reg_wr = wr; reg_addr = addr; reg_wdata = data;
        for (int c = 0; c < 8; c++) begin
            norm_half[c] = ev[2*c];
            norm_done[c] = ev[2*c+1];
            ded_half[c]  = ev[16+2*c];
            ded_done[c]  = ev[17+2*c];
        end
        @(posedge clk); #1;
        reg_sel = 0; reg_wr = 0;
        norm_half = '0; norm_done = '0; ded_half = '0; ded_done = '0;
    endtask

    task automatic rd(string req, logic [7:0] addr, logic [31:0] exp);
        @(negedge clk);
        reg_sel = 1; reg_wr = 0; reg_addr = addr;
        #1 check(req, reg_rdata, exp);
        reg_sel = 0;
    endtask

    task automatic t_reset();
        rd("R1", 8'h00, 32'h0);
        rd("R1", 8'h04, 32'h0);
        check("R1", irq_out, 0);
    endtask

    task automatic t_enable_rw();
        cycle(1, 8'h00, 32'hA5A5_5A5A, 0);
        rd("R2", 8'h00, 32'hA5A5_5A5A);
        check("R7", irq_out, 0);
        cycle(1, 8'h00, 32'h0, 0);
    endtask

    task automatic t_mapping();
        norm_half[3] = 0;
        cycle(0, 0, 0, 32'h0000_0040); // normal ch3 half -> bit 6
        rd("R3", 8'h04, 32'h0000_0040);
        cycle(1, 8'h04, 32'hFFFF_FFFF, 32'h0000_0080); // clear, ch3 done -> bit 7
        rd("R3", 8'h04, 32'h0000_0080);
        cycle(1, 8'h04, 32'hFFFF_FFFF, 0);
        cycle(0, 0, 0, 32'h0010_0000); // dedicated ch2 half -> bit 20
        rd("R3", 8'h04, 32'h0010_0000);
        cycle(1, 8'h04, 32'hFFFF_FFFF, 32'h8000_0000); // dedicated ch7 done -> bit 31
        rd("R3", 8'h04, 32'h8000_0000);
        cycle(1, 8'h04, 32'hFFFF_FFFF, 0);
    endtask

    task automatic t_masked_latch();
        cycle(0, 0, 0, 32'h0000_0003);
        repeat (3) @(posedge clk);
        rd("R4", 8'h04, 32'h0000_0003);
        check("R7", irq_out, 0);
    endtask

    task automatic t_partial_clear();
        cycle(1, 8'h04, 32'h0000_0001, 0);
        rd("R5", 8'h04, 32'h0000_0002);
        cycle(1, 8'h04, 32'h0000_0000, 0);
        rd("R5", 8'h04, 32'h0000_0002);
        cycle(1, 8'h04, 32'hFFFF_FFFF, 0);
    endtask

    task automatic t_collision();
        cycle(0, 0, 0, 32'h0000_0002);
        cycle(1, 8'h04, 32'h0000_0002, 32'h0000_0002);
        rd("R6", 8'h04, 32'h0000_0002);
        cycle(1, 8'h04, 32'hFFFF_FFFF, 0);
    endtask

    task automatic t_irq_mask();
        cycle(1, 8'h00, 32'h0000_0800, 0);
        cycle(0, 0, 0, 32'h0000_0400);
        check("R7", irq_out, 0);
        cycle(0, 0, 0, 32'h0000_0800);
        check("R7", irq_out, 1);
        cycle(1, 8'h00, 32'h0, 0);
        check("R8", irq_out, 0);
        rd("R8", 8'h04, 32'h0000_0C00);
        cycle(1, 8'h04, 32'hFFFF_FFFF, 0);
        rd("R8", 8'h04, 32'h0);
    endtask

    task automatic t_stray();
        cycle(1, 8'h00, 32'h0000_00F0, 0);
        cycle(0, 0, 0, 32'h0000_00C0);
        cycle(1, 8'h08, 32'hFFFF_FFFF, 0);
        rd("R9", 8'h00, 32'h0000_00F0);
        rd("R9", 8'h04, 32'h0000_00C0);
        rd("R9", 8'h08, 32'h0);
        @(negedge clk);
        reg_sel = 0; reg_wr = 1; reg_addr = 8'h04; reg_wdata = 32'hFFFF_FFFF;
        @(posedge clk); #1 reg_wr = 0;
        rd("R9", 8'h04, 32'h0000_00C0);
        check("R7", irq_out, 1);
        cycle(1, 8'h04, 32'hFFFF_FFFF, 0);
        cycle(1, 8'h00, 32'h0, 0);
    endtask

    task automatic t_service();
        cycle(0, 0, 0, 32'h0000_0020);
        rd("R10", 8'h04, 32'h0000_0020);
        cycle(1, 8'h04, 32'h0000_0020, 32'h0001_0000);
        rd("R10", 8'h04, 32'h0001_0000);
        cycle(1, 8'h04, 32'hFFFF_FFFF, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_enable_rw();
        t_mapping();
        t_masked_latch();
        t_partial_clear();
        t_collision();
        t_irq_mask();
        t_stray();
        t_service();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule